// File: doc/BRIEF.md
# Video Active Qualifier Generator

This block produces the per-line video-active qualifier that marks which pixel-clock cycles of an output line carry valid samples. All timing is counted in pixel clocks from the falling (trailing) edge of the horizontal reference input. The horizontal reference is sampled once in the pixel-clock domain to find that edge. The counter restarts at that edge, and the configuration inputs are captured in the same cycle.

Three line types are supported. On a normal line in computed-window mode, the start delay comes from the window begin, the window length and the output pixels-per-line setting. A serial divider works out this delay during the 64-cycle low period of the reference. On a normal line in direct mode, the start and end positions are taken as given. On a blanking-interval data line, a fixed window is used for raw or sliced data, or the qualifier is suppressed for the whole line. Whatever the programmed end, the qualifier is cut 4 cycles before the next expected falling edge; that edge is predicted from the length of the previous line. Each computed-window line updates a status output with the computed delay.

Top module: `vact_gen`

## Requirements
- R1: Cycle 0 is the cycle that begins at the clock edge where `href` is seen low after being high on the previous edge. Cycle k is k clocks later. `vact` is low in cycle 0 of every line.
- R2: In computed-window mode with 0 < `out_pix` < 720, let q = floor((`win_begin`+`win_len`)*720/`out_pix`). `vact` is high for cycles q−`win_len` up to but not including q.
- R3: In computed-window mode with `out_pix` ≥ 720, let s = floor(`win_begin`*720/`out_pix`). `vact` is high for cycles s up to but not including s+`win_len`.
- R4: In computed-window mode with `out_pix` = 0, the divisor is 720, so the window starts at `win_begin` and lasts `win_len` cycles.
- R5: In computed-window mode `vact` is never high before cycle 24. A computed start below 24 moves the first active cycle to 24, and the end stays where it was.
- R6: In direct mode (`free_mode`=1, `vbi_line`=0), `vact` is high for cycles k with max(`free_start`,1) ≤ k < `free_end`. If `free_end` ≤ `free_start`, it is never high.
- R7: `vact` is low in every cycle k with k+4 ≥ L, where L is the cycle count of the previous line. This holds in every mode. L is 2047 until the first full line has been seen.
- R8: On a line with `vbi_line`=1, `vbi_enable`=1 and `vbi_sliced`=1, `vact` is high for cycles 726 to 789, which is 64 cycles.
- R9: On a line with `vbi_line`=1, `vbi_enable`=1 and `vbi_sliced`=0, `vact` is high for cycles 150 to 1289, which is 1140 cycles. `vbi_line`=1 takes priority over `free_mode`.
- R10: On a line with `vbi_line`=1 and `vbi_enable`=0, `vact` stays low for the whole line.
- R11: All configuration inputs are sampled only in the cycle of the falling edge. A change during a line takes effect from the next line.
- R12: `start_status` takes the computed start delay of each computed-window line (before the clamp of R5). It keeps its value through lines of the other types.
- R13: While `rst` is high, `vact` is driven low and `start_status` is cleared on the next clock.
- R14: Within one line, `vact` rises at most once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| href | input | 1 | Horizontal reference; its falling edge starts a line |
| free_mode | input | 1 | 1 selects direct start/end positions, 0 selects the computed window |
| vbi_line | input | 1 | The coming line is a blanking-interval data line |
| vbi_enable | input | 1 | Allow the qualifier on blanking-interval lines |
| vbi_sliced | input | 1 | Blanking-interval data is sliced (1) or raw (0) |
| win_begin | input | 10 | Window begin position |
| win_len | input | 10 | Window length in output pixels |
| out_pix | input | 10 | Output pixels per line |
| free_start | input | 10 | Direct-mode start cycle |
| free_end | input | 10 | Direct-mode end cycle (exclusive) |
| vact | output | 1 | Video-active qualifier |
| start_status | output | 11 | Last computed window start delay |

## Verification
The computed window is driven with pixel counts below, at and above 720. This separates the two formulas and the divide-by-zero fallback. A ratio that does not divide evenly checks that the quotient is truncated. A window that starts below cycle 24 exposes the early-start clamp, and the status then shows the unclamped value. Direct-mode patterns cover an ordinary span, a start of 0 that must lose cycle 0, and an end below the start. Blanking-interval lines are run with both data kinds, with the suppress bit, and with a line too short for the raw window, which separates the fixed lengths from the short-line cutoff. A window edit made in the middle of a line must leave that line unchanged and show up only on the following line.

// File: rtl/vact_pkg.sv
`timescale 1ns/1ps
package vact_pkg;
    localparam int CNT_W     = 11;
    localparam int POS_W     = 10;
    localparam int REF_PIX   = 720;
    localparam int REF_W     = $clog2(REF_PIX + 1);
    localparam int DVD_W     = POS_W + 1 + REF_W;
    localparam int CUT_CYC   = 4;
    localparam int WIN_GUARD = 24;
    localparam int RAW_START = 150;
    localparam int RAW_LEN   = 1140;
    localparam int SLC_START = 726;
    localparam int SLC_LEN   = 64;

    typedef logic [CNT_W-1:0] pix_t;
    typedef logic [POS_W-1:0] pos_t;

    typedef enum logic [1:0] {
        LN_WINDOW = 2'd0,
        LN_FREE   = 2'd1,
        LN_RAW    = 2'd2,
        LN_SLICED = 2'd3
    } line_kind_e;

    typedef struct packed {
        line_kind_e kind;
        logic       vbi_on;
        pos_t       hbeg;
        pos_t       hlen;
        pos_t       npix;
        pos_t       fstart;
        pos_t       fend;
    } line_cfg_t;

    typedef struct packed {
        pix_t first;
        pix_t stop;
        logic valid;
    } span_t;

    localparam logic [DVD_W-1:0] PIX_MAX_W = DVD_W'((1 << CNT_W) - 1);

    function automatic pix_t sat_pix(input logic [DVD_W-1:0] v);
        if (v > PIX_MAX_W) return '1;
        return v[CNT_W-1:0];
    endfunction

    function automatic pix_t sat_add(input pix_t a, input pos_t b);
        logic [CNT_W:0] s;
        s = {1'b0, a} + (CNT_W+1)'(b);
        return s[CNT_W] ? '1 : s[CNT_W-1:0];
    endfunction
endpackage

// File: rtl/vact_linetimer.sv
`timescale 1ns/1ps
module vact_linetimer
    import vact_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic href,
    output logic fall,
    output pix_t cnt,
    output pix_t line_len
);
    logic href_q;

    always_comb fall = href_q & ~href;

    always_ff @(posedge clk) begin
        if (rst) begin
            href_q   <= 1'b0;
            cnt      <= '0;
            line_len <= '1;
        end else begin
            href_q <= href;
            if (fall) begin
                cnt      <= '0;
                line_len <= sat_add(cnt, pos_t'(1));
            end else begin
                cnt <= sat_add(cnt, pos_t'(1));
            end
        end
    end
endmodule

// File: rtl/vact_divider.sv
`timescale 1ns/1ps
module vact_divider
    import vact_pkg::*;
#(
    parameter int N_W = DVD_W,
    parameter int D_W = POS_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [N_W-1:0] num,
    input  logic [D_W-1:0] den,
    output logic [N_W-1:0] quo,
    output logic           done
);
    localparam int STEP_W = $clog2(N_W + 1);

    logic [N_W-1:0]    num_sh;
    logic [D_W-1:0]    rem;
    logic [D_W-1:0]    den_q;
    logic [STEP_W-1:0] steps;
    logic [D_W:0]      trial;
    logic [D_W:0]      diff;
    logic              fits;

    always_comb begin
        trial = {rem, num_sh[N_W-1]};
        fits  = trial >= {1'b0, den_q};
        diff  = trial - {1'b0, den_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            num_sh <= '0;
            rem    <= '0;
            den_q  <= '0;
            quo    <= '0;
            steps  <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                num_sh <= num;
                den_q  <= den;
                rem    <= '0;
                quo    <= '0;
                steps  <= STEP_W'(N_W);
            end else if (steps != '0) begin
                num_sh <= num_sh << 1;
                rem    <= fits ? diff[D_W-1:0] : trial[D_W-1:0];
                quo    <= {quo[N_W-2:0], fits};
                steps  <= steps - 1'b1;
                if (steps == STEP_W'(1)) done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/vact_span.sv
`timescale 1ns/1ps
module vact_span
    import vact_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fall,
    input  line_cfg_t        cfg_in,
    input  logic [DVD_W-1:0] quo,
    input  logic             done,
    output logic [DVD_W-1:0] num,
    output pos_t             den,
    output span_t            span,
    output pix_t             stat
);
    logic           narrow;
    logic [POS_W:0] base;
    line_kind_e     kind_q;
    logic           narrow_q;
    pos_t           hlen_q;
    pix_t           q_sat;
    pix_t           ws;
    pix_t           we;
    pix_t           first;

    always_comb begin
        narrow = (cfg_in.npix != '0) && (cfg_in.npix < pos_t'(REF_PIX));
        den    = (cfg_in.npix == '0) ? pos_t'(REF_PIX) : cfg_in.npix;
        base   = narrow ? ({1'b0, cfg_in.hbeg} + {1'b0, cfg_in.hlen})
                        : {1'b0, cfg_in.hbeg};
        num    = DVD_W'(base) * DVD_W'(REF_PIX);
    end

    always_comb begin
        q_sat = sat_pix(quo);
        ws    = narrow_q ? (q_sat - pix_t'(hlen_q)) : q_sat;
        we    = sat_add(ws, hlen_q);
        first = (ws < pix_t'(WIN_GUARD)) ? pix_t'(WIN_GUARD) : ws;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q   <= LN_WINDOW;
            narrow_q <= 1'b0;
            hlen_q   <= '0;
            span     <= '0;
            stat     <= '0;
        end else if (fall) begin
            kind_q   <= cfg_in.kind;
            narrow_q <= narrow;
            hlen_q   <= cfg_in.hlen;
            case (cfg_in.kind)
                LN_FREE: begin
                    span.first <= pix_t'(cfg_in.fstart);
                    span.stop  <= pix_t'(cfg_in.fend);
                    span.valid <= 1'b1;
                end
                LN_RAW: begin
                    span.first <= pix_t'(RAW_START);
                    span.stop  <= pix_t'(RAW_START + RAW_LEN);
                    span.valid <= cfg_in.vbi_on;
                end
                LN_SLICED: begin
                    span.first <= pix_t'(SLC_START);
                    span.stop  <= pix_t'(SLC_START + SLC_LEN);
                    span.valid <= cfg_in.vbi_on;
                end
                default: begin
                    span.first <= '0;
                    span.stop  <= '0;
                    span.valid <= 1'b0;
                end
            endcase
        end else if (done && kind_q == LN_WINDOW) begin
            span.first <= first;
            span.stop  <= we;
            span.valid <= 1'b1;
            stat       <= ws;
        end
    end
endmodule

// File: rtl/vact_gen.sv
`timescale 1ns/1ps
module vact_gen
    import vact_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             href,
    input  logic             free_mode,
    input  logic             vbi_line,
    input  logic             vbi_enable,
    input  logic             vbi_sliced,
    input  logic [POS_W-1:0] win_begin,
    input  logic [POS_W-1:0] win_len,
    input  logic [POS_W-1:0] out_pix,
    input  logic [POS_W-1:0] free_start,
    input  logic [POS_W-1:0] free_end,
    output logic             vact,
    output logic [CNT_W-1:0] start_status
);
    logic             fall;
    pix_t             cnt;
    pix_t             line_len;
    line_cfg_t        cfg_in;
    logic [DVD_W-1:0] num;
    pos_t             den;
    logic [DVD_W-1:0] quo;
    logic             done;
    span_t            span;
    logic [CNT_W:0]   k_next;
    logic             hit;

    always_comb begin
        if (vbi_line)       cfg_in.kind = vbi_sliced ? LN_SLICED : LN_RAW;
        else if (free_mode) cfg_in.kind = LN_FREE;
        else                cfg_in.kind = LN_WINDOW;
        cfg_in.vbi_on = vbi_enable;
        cfg_in.hbeg   = win_begin;
        cfg_in.hlen   = win_len;
        cfg_in.npix   = out_pix;
        cfg_in.fstart = free_start;
        cfg_in.fend   = free_end;
    end

    vact_linetimer i_timer (
        .clk      (clk),
        .rst      (rst),
        .href     (href),
        .fall     (fall),
        .cnt      (cnt),
        .line_len (line_len)
    );

    vact_divider #(.N_W(DVD_W), .D_W(POS_W)) i_div (
        .clk   (clk),
        .rst   (rst),
        .start (fall),
        .num   (num),
        .den   (den),
        .quo   (quo),
        .done  (done)
    );

    vact_span i_span (
        .clk    (clk),
        .rst    (rst),
        .fall   (fall),
        .cfg_in (cfg_in),
        .quo    (quo),
        .done   (done),
        .num    (num),
        .den    (den),
        .span   (span),
        .stat   (start_status)
    );

    always_comb begin
        k_next = {1'b0, cnt} + (CNT_W+1)'(1);
        hit    = span.valid
              && (k_next >= {1'b0, span.first})
              && (k_next <  {1'b0, span.stop})
              && ((k_next + (CNT_W+1)'(CUT_CYC)) < {1'b0, line_len});
    end

    always_ff @(posedge clk) begin
        if (rst) vact <= 1'b0;
        else     vact <= hit && !fall;
    end
endmodule

// File: rtl/vact_gen_chk.sv
`timescale 1ns/1ps
module vact_gen_chk
    import vact_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             href,
    input logic             free_mode,
    input logic             vbi_line,
    input logic             vbi_enable,
    input logic             vact,
    input logic [CNT_W-1:0] start_status
);
    logic c_hq;
    logic c_fall;
    pix_t c_cnt;
    pix_t c_prev_len;
    logic c_win;
    logic c_vbi_off;
    logic c_seen;

    always_comb c_fall = c_hq & ~href;

    always_ff @(posedge clk) begin
        if (rst) begin
            c_hq       <= 1'b0;
            c_cnt      <= '0;
            c_prev_len <= '1;
            c_win      <= 1'b0;
            c_vbi_off  <= 1'b0;
            c_seen     <= 1'b0;
        end else begin
            c_hq <= href;
            if (c_fall) begin
                c_cnt      <= '0;
                c_prev_len <= sat_add(c_cnt, pos_t'(1));
                c_win      <= !free_mode && !vbi_line;
                c_vbi_off  <= vbi_line && !vbi_enable;
                c_seen     <= 1'b0;
            end else begin
                c_cnt <= sat_add(c_cnt, pos_t'(1));
                if (vact) c_seen <= 1'b1;
            end
        end
    end

    p_reset_r13: assert property (@(posedge clk)
        rst |=> (!vact && start_status == '0));

    p_edge_low_r1: assert property (@(posedge clk) disable iff (rst)
        c_fall |=> !vact);

    p_guard_r5: assert property (@(posedge clk) disable iff (rst)
        (c_win && c_cnt < pix_t'(WIN_GUARD)) |-> !vact);

    p_cutoff_r7: assert property (@(posedge clk) disable iff (rst)
        vact |-> (({1'b0, c_cnt} + (CNT_W+1)'(CUT_CYC)) < {1'b0, c_prev_len}));

    p_vbi_off_r10: assert property (@(posedge clk) disable iff (rst)
        c_vbi_off |-> !vact);

    p_status_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !$stable(start_status) |-> (c_win || $past(rst)));

    p_one_run_r14: assert property (@(posedge clk) disable iff (rst)
        $rose(vact) |-> !c_seen);
endmodule

bind vact_gen vact_gen_chk i_vact_gen_chk (
    .clk          (clk),
    .rst          (rst),
    .href         (href),
    .free_mode    (free_mode),
    .vbi_line     (vbi_line),
    .vbi_enable   (vbi_enable),
    .vact         (vact),
    .start_status (start_status)
);

// File: tb/test_vact_gen.sv
`timescale 1ns/1ps
module test_vact_gen;
    logic        clk = 1'b0;
    logic        rst;
    logic        href;
    logic        free_mode;
    logic        vbi_line;
    logic        vbi_enable;
    logic        vbi_sliced;
    logic [9:0]  win_begin;
    logic [9:0]  win_len;
    logic [9:0]  out_pix;
    logic [9:0]  free_start;
    logic [9:0]  free_end;
    logic        vact;
    logic [10:0] start_status;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    vact_gen i_vact_gen (
        .clk          (clk),
        .rst          (rst),
        .href         (href),
        .free_mode    (free_mode),
        .vbi_line     (vbi_line),
        .vbi_enable   (vbi_enable),
        .vbi_sliced   (vbi_sliced),
        .win_begin    (win_begin),
        .win_len      (win_len),
        .out_pix      (out_pix),
        .free_start   (free_start),
        .free_end     (free_end),
        .vact         (vact),
        .start_status (start_status)
    );

    typedef struct packed {
        int rq;
        bit fm; bit vl; bit ve; bit vs;
        int hb; int hl; int np; int fs; int fe;
        int len; int efirst; int ecnt; int estat;
    } vec_t;

    // efirst -1: never high; estat -1: status unchanged from the last window line
    localparam vec_t VECS [0:14] = '{
        '{2,  0,0,0,0, 100,640,640,   0,  0,  900, 192, 640, 192},  // R2
        '{3,  0,0,0,0,  80,700,720,   0,  0,  864,  80, 700,  80},  // R3
        '{3,  0,0,0,0, 100,600,800,   0,  0,  864,  90, 600,  90},  // R3
        '{2,  0,0,0,0,  20,300,360,   0,  0,  864, 340, 300, 340},  // R2
        '{2,  0,0,0,0,  50,500,700,   0,  0,  864,  65, 500,  65},  // R2 truncation
        '{7,  0,0,0,0, 200,700,720,   0,  0,  800, 200, 596, 200},  // R7 short line
        '{5,  0,0,0,0,  10,100,720,   0,  0,  864,  24,  86,  10},  // R5 clamp
        '{4,  0,0,0,0, 120,200,  0,   0,  0,  864, 120, 200, 120},  // R4
        '{6,  1,0,0,0,   0,  0,  0, 100,400,  864, 100, 300,  -1},  // R6
        '{1,  1,0,0,0,   0,  0,  0,   0, 10,  864,   1,   9,  -1},  // R1
        '{6,  1,0,0,0,   0,  0,  0, 300,200,  864,  -1,   0,  -1},  // R6 empty
        '{8,  0,1,1,1,   0,  0,  0,   0,  0,  864, 726,  64,  -1},  // R8
        '{9,  1,1,1,0,   0,  0,  0, 100,400, 1400, 150,1140,  -1},  // R9
        '{7,  0,1,1,0,   0,  0,  0,   0,  0,  864, 150, 710,  -1},  // R7 with raw data
        '{10, 1,1,0,1,   0,  0,  0, 100,400,  864,  -1,   0,  -1}   // R10
    };

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_line(input int len, input int chg_at, input int chg_val,
                            output int first, output int cnt, output int rises);
        logic prev;
        first = -1; cnt = 0; rises = 0; prev = 1'b0;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            href = (k < 64) ? 1'b0 : 1'b1;
            if (k == chg_at) win_begin = 10'(chg_val);
            @(posedge clk);
            #1;
            if (vact) begin
                if (first < 0) first = k;
                cnt++;
                if (!prev) rises++;
            end
            prev = vact;
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        free_mode  = v.fm;
        vbi_line   = v.vl;
        vbi_enable = v.ve;
        vbi_sliced = v.vs;
        win_begin  = 10'(v.hb);
        win_len    = 10'(v.hl);
        out_pix    = 10'(v.np);
        free_start = 10'(v.fs);
        free_end   = 10'(v.fe);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int f, c, r, last_stat;
        rst = 1'b1; href = 1'b1;
        free_mode = 0; vbi_line = 0; vbi_enable = 0; vbi_sliced = 0;
        win_begin = '0; win_len = '0; out_pix = '0; free_start = '0; free_end = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R13 reset vact", int'(vact), 0);
        check("R13 reset status", int'(start_status), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        last_stat = 0;

        foreach (VECS[i]) begin
            apply(VECS[i]);
            run_line(VECS[i].len, -1, 0, f, c, r);
            run_line(VECS[i].len, -1, 0, f, c, r);
            check($sformatf("R%0d vec %0d first", VECS[i].rq, i), f, VECS[i].efirst);
            check($sformatf("R%0d vec %0d count", VECS[i].rq, i), c, VECS[i].ecnt);
            check($sformatf("R14 vec %0d runs", i), r, (VECS[i].ecnt > 0) ? 1 : 0);
            if (VECS[i].estat >= 0) last_stat = VECS[i].estat;
            check($sformatf("R12 vec %0d status", i), int'(start_status), last_stat);
        end

        // R11: mid-line window edit applies only from the next line
        apply(VECS[1]);
        run_line(864, -1, 0, f, c, r);
        run_line(864, 100, 300, f, c, r);
        check("R11 current line first", f, 80);
        check("R11 current line count", c, 700);
        run_line(864, -1, 0, f, c, r);
        check("R11 next line first", f, 300);
        check("R11 next line count", c, 560);
        check("R11 next line status", int'(start_status), 300);

        // R13: reset in the middle of an active span
        apply(VECS[8]);
        run_line(864, -1, 0, f, c, r);
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            href = (k < 64) ? 1'b0 : 1'b1;
        end
        @(posedge clk); #1;
        check("R6 span active before reset", int'(vact), 1);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1;
        check("R13 mid-line reset vact", int'(vact), 0);
        check("R13 mid-line reset status", int'(start_status), 0);
        @(negedge clk);
        rst = 1'b0;

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule